// File: doc/BRIEF.md
# DMA Controller Register File

This block is the software-visible register file of a four-channel DMA controller. A processor talks to it through a byte-wide, I/O-style port: a 4-bit register offset, a write strobe, a read strobe and one byte of data each way. Each channel has a 16-bit address and a 16-bit transfer count. The port is only one byte wide, so these values are loaded and read one byte at a time. A hidden byte pointer selects the low or the high half. Every write to a channel register lands in both the working (current) copy and the reload (base) copy.

The block also holds the per-channel mode bytes, a command byte, a request byte, a four-bit channel mask, a status byte and a temporary byte. All of these are driven out as registered outputs to a separate transfer engine. The engine sends back single-cycle pulses that set terminal-count flags, set or clear request-pending flags, and load the temporary byte. Reading status returns the flags and then clears the terminal-count half.

Read data is registered. The value for a read strobed on one clock edge appears on `rd_data` after that edge and holds until the next accepted read.

Top module: `dma_regfile`

## Requirements
- R1: After a synchronous reset, every register, the mask, the status byte, the byte pointer and `rd_data` are all zero.
- R2: A write or read at an offset below 8 targets channel `offset>>1`. An even offset selects the address register and an odd offset selects the count register. The low byte is used when the byte pointer is 0 and the high byte when it is 1. The pointer toggles after each such access.
- R3: A channel address or count write loads the same byte into both the current copy and the base copy.
- R4: A read at offset 0–7 returns the byte of the current register that the byte pointer selects.
- R5: A write to offset 0xA changes only the mask bit of the channel given by data bits 1:0. The new value of that bit is data bit 2.
- R6: A write to offset 0xB stores the data byte as the mode of the channel given by bits 1:0. Bits 3:2 are the transfer type, bit 4 is autoreload, bit 5 is address decrement and bits 7:6 are the mode (3 = cascade). Writes to 0x8 and 0x9 load the command byte and the request byte.
- R7: A write to offset 0xC clears the byte pointer.
- R8: A write to offset 0xD clears the byte pointer and the whole status byte, and sets all four mask bits.
- R9: A write to offset 0xE clears all mask bits. A write to offset 0xF loads mask bits 3:0 from the data, where 1 means masked.
- R10: A read at offset 0x8 returns status (request-pending flags in bits 7:4, terminal-count flags in bits 3:0). The terminal-count bits are cleared after the read, and the request bits are kept.
- R11: Terminal-count and request-pending set pulses are applied after any clear in the same cycle. A terminal-count pulse that coincides with a status read therefore shows in the next status read. A request clear pulse removes the flag.
- R12: A read at 0xD returns the temporary byte, which the engine loads. A read at 0xF returns ones in bits 7:4 with the mask in bits 3:0. A read at 0x9, 0xA, 0xB, 0xC or 0xE returns 0xFF.
- R13: When the read and write strobes are both high in one cycle, the write is performed, the read is ignored and `rd_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_off | input | 4 | Register offset |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| tc_set | input | 4 | Per-channel terminal-count set pulses from the engine |
| rq_set | input | 4 | Per-channel request-pending set pulses |
| rq_clr | input | 4 | Per-channel request-pending clear pulses |
| tmp_we | input | 1 | Temporary byte load strobe from the engine |
| tmp_din | input | 8 | Temporary byte value |
| base_addr | output | 4x16 | Base address per channel |
| cur_addr | output | 4x16 | Current address per channel |
| base_cnt | output | 4x16 | Base count per channel |
| cur_cnt | output | 4x16 | Current count per channel |
| mode | output | 4x8 | Mode byte per channel |
| cmd | output | 8 | Command byte |
| req | output | 8 | Request byte |
| mask | output | 4 | Channel mask, 1 = masked |

## Verification
The byte pointer is the dangerous piece of hidden state. If it falls out of step, the next channel access swaps the byte halves, and the fault shows on the very next channel read or on the engine-facing address and count outputs one cycle later. The bench therefore reads channel registers back right after pointer clears and after a master clear. A status flag lost or kept too long shows at the second status read. The test that catches it pairs a status read with a coinciding set pulse and then reads status again.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam logic [3:0] OFF_CMD_STAT = 4'h8;
  localparam logic [3:0] OFF_REQ      = 4'h9;
  localparam logic [3:0] OFF_SMASK    = 4'hA;
  localparam logic [3:0] OFF_MODE     = 4'hB;
  localparam logic [3:0] OFF_PTR_CLR  = 4'hC;
  localparam logic [3:0] OFF_MCLR_TMP = 4'hD;
  localparam logic [3:0] OFF_MASK_CLR = 4'hE;
  localparam logic [3:0] OFF_MASK_ALL = 4'hF;

  typedef struct packed {
    logic [1:0] xfer_mode;  // 3 = cascade
    logic       addr_dec;
    logic       auto_rld;
    logic [1:0] xfer_type;
    logic [1:0] chan_sel;
  } mode_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_we,
  input  logic            cnt_we,
  input  logic            hi_byte,
  input  logic            mode_we,
  input  logic [DW-1:0]   din,
  output logic [2*DW-1:0] base_addr_q,
  output logic [2*DW-1:0] cur_addr_q,
  output logic [2*DW-1:0] base_cnt_q,
  output logic [2*DW-1:0] cur_cnt_q,
  output logic [DW-1:0]   mode_q
);
  localparam int AW = 2 * DW;

  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] old,
                                             input logic          hi,
                                             input logic [DW-1:0] b);
    return hi ? {b, old[DW-1:0]} : {old[AW-1:DW], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
    end else begin
      if (addr_we) begin
        base_addr_q <= put_byte(base_addr_q, hi_byte, din);
        cur_addr_q  <= put_byte(cur_addr_q, hi_byte, din);
      end
      if (cnt_we) begin
        base_cnt_q <= put_byte(base_cnt_q, hi_byte, din);
        cur_cnt_q  <= put_byte(cur_cnt_q, hi_byte, din);
      end
      if (mode_we) mode_q <= din;
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             req_we,
  input  logic             smask_we,
  input  logic             mall_we,
  input  logic             mzero_we,
  input  logic             mclr_we,
  input  logic             ptr_clr_we,
  input  logic             chan_acc,
  input  logic             stat_rd,
  input  logic [DW-1:0]    din,
  input  logic [NCH-1:0]   tc_set,
  input  logic [NCH-1:0]   rq_set,
  input  logic [NCH-1:0]   rq_clr,
  input  logic             tmp_we,
  input  logic [DW-1:0]    tmp_din,
  output logic [DW-1:0]    cmd_q,
  output logic [DW-1:0]    req_q,
  output logic [NCH-1:0]   mask_q,
  output logic [2*NCH-1:0] stat_q,
  output logic [DW-1:0]    tmp_q,
  output logic             ptr_q
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0] tc_n, rq_n;

  always_comb begin
    tc_n = stat_q[NCH-1:0];
    rq_n = stat_q[2*NCH-1:NCH] & ~rq_clr;
    if (stat_rd || mclr_we) tc_n = '0;
    if (mclr_we) rq_n = '0;
    tc_n = tc_n | tc_set;
    rq_n = rq_n | rq_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      req_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
      tmp_q  <= '0;
      ptr_q  <= 1'b0;
    end else begin
      stat_q <= {rq_n, tc_n};
      if (cmd_we) cmd_q <= din;
      if (req_we) req_q <= din;
      if (tmp_we) tmp_q <= tmp_din;
      if (mclr_we)       mask_q <= '1;
      else if (mzero_we) mask_q <= '0;
      else if (mall_we)  mask_q <= din[NCH-1:0];
      else if (smask_we) mask_q[din[CH_W-1:0]] <= din[CH_W];
      if (mclr_we || ptr_clr_we) ptr_q <= 1'b0;
      else if (chan_acc)         ptr_q <= ~ptr_q;
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [3:0]                  reg_off,
  input  logic [DW-1:0]               wr_data,
  output logic [DW-1:0]               rd_data,
  input  logic [NCH-1:0]              tc_set,
  input  logic [NCH-1:0]              rq_set,
  input  logic [NCH-1:0]              rq_clr,
  input  logic                        tmp_we,
  input  logic [DW-1:0]               tmp_din,
  output logic [NCH-1:0][2*DW-1:0]    base_addr,
  output logic [NCH-1:0][2*DW-1:0]    cur_addr,
  output logic [NCH-1:0][2*DW-1:0]    base_cnt,
  output logic [NCH-1:0][2*DW-1:0]    cur_cnt,
  output logic [NCH-1:0][DW-1:0]      mode,
  output logic [DW-1:0]               cmd,
  output logic [DW-1:0]               req,
  output logic [NCH-1:0]              mask
);
  import dma_regs_pkg::*;

  localparam int CH_W = $clog2(NCH);

  logic                wr_go, rd_go, chan_hit, ptr_w;
  logic [CH_W-1:0]     ch_idx;
  logic [2*NCH-1:0]    stat_w;
  logic [DW-1:0]       tmp_w;
  logic [DW-1:0]       rd_n;
  logic [2*DW-1:0]     sel_reg;
  mode_t               mode_wr;

  assign wr_go    = wr_en;
  assign rd_go    = rd_en & ~wr_en;
  assign chan_hit = ~reg_off[3];
  assign ch_idx   = reg_off[CH_W:1];
  assign mode_wr  = mode_t'(wr_data);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit_c;
    assign hit_c = wr_go && chan_hit && (ch_idx == CH_W'(c));
    dma_chan_regs #(.DW(DW)) chan_i (
      .clk        (clk),
      .rst        (rst),
      .addr_we    (hit_c && !reg_off[0]),
      .cnt_we     (hit_c && reg_off[0]),
      .hi_byte    (ptr_w),
      .mode_we    (wr_go && reg_off == OFF_MODE && mode_wr.chan_sel == 2'(c)),
      .din        (wr_data),
      .base_addr_q(base_addr[c]),
      .cur_addr_q (cur_addr[c]),
      .base_cnt_q (base_cnt[c]),
      .cur_cnt_q  (cur_cnt[c]),
      .mode_q     (mode[c])
    );
  end

  dma_ctrl_regs #(.NCH(NCH), .DW(DW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (wr_go && reg_off == OFF_CMD_STAT),
    .req_we    (wr_go && reg_off == OFF_REQ),
    .smask_we  (wr_go && reg_off == OFF_SMASK),
    .mall_we   (wr_go && reg_off == OFF_MASK_ALL),
    .mzero_we  (wr_go && reg_off == OFF_MASK_CLR),
    .mclr_we   (wr_go && reg_off == OFF_MCLR_TMP),
    .ptr_clr_we(wr_go && reg_off == OFF_PTR_CLR),
    .chan_acc  ((wr_go || rd_go) && chan_hit),
    .stat_rd   (rd_go && reg_off == OFF_CMD_STAT),
    .din       (wr_data),
    .tc_set    (tc_set),
    .rq_set    (rq_set),
    .rq_clr    (rq_clr),
    .tmp_we    (tmp_we),
    .tmp_din   (tmp_din),
    .cmd_q     (cmd),
    .req_q     (req),
    .mask_q    (mask),
    .stat_q    (stat_w),
    .tmp_q     (tmp_w),
    .ptr_q     (ptr_w)
  );

  assign sel_reg = reg_off[0] ? cur_cnt[ch_idx] : cur_addr[ch_idx];

  always_comb begin
    if (chan_hit)                        rd_n = ptr_w ? sel_reg[2*DW-1:DW] : sel_reg[DW-1:0];
    else if (reg_off == OFF_CMD_STAT)    rd_n = DW'(stat_w);
    else if (reg_off == OFF_MCLR_TMP)    rd_n = tmp_w;
    else if (reg_off == OFF_MASK_ALL)    rd_n = {{(DW-NCH){1'b1}}, mask};
    else                                 rd_n = '1;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_go) rd_data <= rd_n;
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [3:0]       reg_off,
  input logic [DW-1:0]    rd_data,
  input logic [NCH-1:0]   mask,
  input logic [NCH-1:0]   tc_set,
  input logic [2*NCH-1:0] stat
);
  p_mclr_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_off == 4'hD) |=> (mask == '1));

  p_mask_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_off == 4'hE) |=> (mask == '0));

  p_unmapped_ff_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && reg_off == 4'h9) |=> (rd_data == '1));

  p_tc_cleared_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && reg_off == 4'h8 && tc_set == '0) |=> (stat[NCH-1:0] == '0));

  p_tc_survives_r11: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0) |=> ((stat[NCH-1:0] & $past(tc_set)) == $past(tc_set)));

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || wr_en) |=> $stable(rd_data));
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .reg_off(reg_off),
  .rd_data(rd_data),
  .mask   (mask),
  .tc_set (tc_set),
  .stat   (stat_w)
);

// File: tb/dma_regfile_tb_top.sv
`timescale 1ns/1ps
module dma_regfile_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int NV  = 30;

  logic clk = 1'b0;
  logic rst, wr_en, rd_en, tmp_we;
  logic [3:0] reg_off;
  logic [DW-1:0] wr_data, rd_data, tmp_din, cmd, req;
  logic [NCH-1:0] tc_set, rq_set, rq_clr, mask;
  logic [NCH-1:0][2*DW-1:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [NCH-1:0][DW-1:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dma_regfile #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_off(reg_off),
    .wr_data(wr_data), .rd_data(rd_data), .tc_set(tc_set), .rq_set(rq_set),
    .rq_clr(rq_clr), .tmp_we(tmp_we), .tmp_din(tmp_din),
    .base_addr(base_addr), .cur_addr(cur_addr), .base_cnt(base_cnt),
    .cur_cnt(cur_cnt), .mode(mode), .cmd(cmd), .req(req), .mask(mask)
  );

  // entry: {wr, rd, off[3:0], data[7:0], chk, exp[7:0], req_no[3:0]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,1'b0,4'hC,8'h00,1'b0,8'h00,4'd7},   // R7 pointer to low
    {1'b1,1'b0,4'h2,8'h34,1'b0,8'h00,4'd2},   // R2 ch1 addr low
    {1'b1,1'b0,4'h2,8'h12,1'b0,8'h00,4'd2},   // R2 ch1 addr high
    {1'b0,1'b1,4'h2,8'h00,1'b1,8'h34,4'd4},   // R4 read low
    {1'b0,1'b1,4'h2,8'h00,1'b1,8'h12,4'd2},   // R2 read high
    {1'b1,1'b0,4'h3,8'hCD,1'b0,8'h00,4'd2},
    {1'b1,1'b0,4'h3,8'hAB,1'b0,8'h00,4'd2},
    {1'b0,1'b1,4'h3,8'h00,1'b1,8'hCD,4'd2},   // R2 count low
    {1'b1,1'b0,4'hC,8'h00,1'b0,8'h00,4'd7},
    {1'b0,1'b1,4'h3,8'h00,1'b1,8'hCD,4'd7},   // R7 low again after clear
    {1'b1,1'b0,4'hC,8'h00,1'b0,8'h00,4'd7},
    {1'b1,1'b0,4'hF,8'h05,1'b0,8'h00,4'd9},
    {1'b0,1'b1,4'hF,8'h00,1'b1,8'hF5,4'd9},   // R9 mask load
    {1'b1,1'b0,4'hA,8'h02,1'b0,8'h00,4'd5},
    {1'b0,1'b1,4'hF,8'h00,1'b1,8'hF1,4'd5},   // R5 ch2 unmasked
    {1'b1,1'b0,4'hA,8'h07,1'b0,8'h00,4'd5},
    {1'b0,1'b1,4'hF,8'h00,1'b1,8'hF9,4'd5},   // R5 ch3 masked
    {1'b1,1'b0,4'hE,8'h00,1'b0,8'h00,4'd9},
    {1'b0,1'b1,4'hF,8'h00,1'b1,8'hF0,4'd9},   // R9 mask clear
    {1'b1,1'b0,4'h0,8'h11,1'b0,8'h00,4'd8},   // pointer now 1
    {1'b1,1'b0,4'hD,8'h00,1'b0,8'h00,4'd8},   // R8 master clear
    {1'b0,1'b1,4'hF,8'h00,1'b1,8'hFF,4'd8},
    {1'b0,1'b1,4'h0,8'h00,1'b1,8'h11,4'd8},   // R8 pointer was cleared
    {1'b0,1'b1,4'h8,8'h00,1'b1,8'h00,4'd10},
    {1'b0,1'b1,4'h9,8'h00,1'b1,8'hFF,4'd12},  // R12 unmapped
    {1'b0,1'b1,4'hA,8'h00,1'b1,8'hFF,4'd12},
    {1'b0,1'b1,4'hB,8'h00,1'b1,8'hFF,4'd12},
    {1'b0,1'b1,4'hC,8'h00,1'b1,8'hFF,4'd12},
    {1'b0,1'b1,4'hE,8'h00,1'b1,8'hFF,4'd12},
    {1'b0,1'b1,4'hD,8'h00,1'b1,8'h00,4'd12}   // R12 temp
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [3:0] o, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; reg_off = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; reg_off = 0; wr_data = 0;
    tc_set = 0; rq_set = 0; rq_clr = 0; tmp_we = 0; tmp_din = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rd_data", 32'(rd_data), 32'h0);
    check("R1 mask", 32'(mask), 32'h0);
    check("R1 cmd", 32'(cmd), 32'h0);
    check("R1 mode0", 32'(mode[0]), 32'h0);
    check("R1 cur_addr1", 32'(cur_addr[1]), 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][26], VEC[i][25], VEC[i][24:21], VEC[i][20:13]);
      if (VEC[i][12])
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), 32'(rd_data), 32'(VEC[i][11:4]));
    end

    // R3 base and current copies
    check("R3 base_addr1", 32'(base_addr[1]), 32'h1234);
    check("R3 cur_addr1", 32'(cur_addr[1]), 32'h1234);
    check("R3 base_cnt1", 32'(base_cnt[1]), 32'hABCD);
    check("R3 cur_cnt1", 32'(cur_cnt[1]), 32'hABCD);

    // R6 mode, command, request
    op(1, 0, 4'hB, 8'hB6);
    check("R6 mode2", 32'(mode[2]), 32'hB6);
    check("R6 mode0 kept", 32'(mode[0]), 32'h0);
    op(1, 0, 4'h8, 8'h44);
    check("R6 cmd", 32'(cmd), 32'h44);
    op(1, 0, 4'h9, 8'h06);
    check("R6 req", 32'(req), 32'h06);

    // R10 / R11 status
    @(negedge clk); tc_set = 4'b0011; rq_set = 4'b1000;
    @(negedge clk); tc_set = 0; rq_set = 0;
    op(0, 1, 4'h8, 0);
    check("R10 status", 32'(rd_data), 32'h83);
    op(0, 1, 4'h8, 0);
    check("R10 tc cleared", 32'(rd_data), 32'h80);
    @(negedge clk); rd_en = 1; reg_off = 4'h8; tc_set = 4'b0100;
    @(negedge clk); rd_en = 0; tc_set = 0;
    check("R11 read with pulse", 32'(rd_data), 32'h80);
    op(0, 1, 4'h8, 0);
    check("R11 pulse kept", 32'(rd_data), 32'h84);
    @(negedge clk); rq_clr = 4'b1000;
    @(negedge clk); rq_clr = 0;
    op(0, 1, 4'h8, 0);
    check("R11 rq clear", 32'(rd_data), 32'h00);

    // R12 temporary byte
    @(negedge clk); tmp_we = 1; tmp_din = 8'h5A;
    @(negedge clk); tmp_we = 0;
    op(0, 1, 4'hD, 0);
    check("R12 temp", 32'(rd_data), 32'h5A);
    check("R12 temp read no clear", 32'(mask), 32'hF);

    // R13 simultaneous strobes
    op(1, 1, 4'hF, 8'h0A);
    check("R13 rd_data held", 32'(rd_data), 32'h5A);
    check("R13 write done", 32'(mask), 32'hA);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 mask after reset", 32'(mask), 32'h0);
    check("R1 cmd after reset", 32'(cmd), 32'h0);
    check("R1 addr after reset", 32'(cur_addr[1]), 32'h0);
    check("R1 rd_data after reset", 32'(rd_data), 32'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule